// File: doc/BRIEF.md
# Burst-Gated Serial Word Transmitter

This block sends 32-bit words, taken from a FIFO-style source with a valid/ready handshake, out as a serial bit stream. A single system clock runs the logic. An external per-bit strobe sets the bit rate, so the block moves one bit slot forward on each strobe. With the data line it drives a serial clock and a data-enable line.

The enable line follows a repeating pattern. A burst holds enable high for 32·M bit slots, then a gap holds it low for N bit slots. M and N come from two 8-bit configuration inputs. An external device can hold off the start of a new burst with its busy input. A burst that has already begun always runs to its end.

If the word source runs dry inside a burst, enable drops and the burst pauses. When words return, the burst resumes, and its total enabled length stays 32·M. An M of zero stops transmission.

Top module: `burst_gated_tx`

## Requirements
- R1: While reset is held and after it is released with no strobe, ser_en and ser_data are 0, ser_clk is 1 and word_ready is 0.
- R2: With words available, every burst holds ser_en high for exactly 32·cfg_burst_words strobe slots. For example, cfg_burst_words = 4 gives a 128-slot burst.
- R3: After a burst ends, ser_en stays low for exactly cfg_gap_bits strobe slots before the next burst can start. A cfg_gap_bits of 0 starts the next burst on the strobe right after the last bit.
- R4: Words go out least-significant bit first, one bit per strobe slot. Outputs change only on the clock edge at which bit_stb is 1. ser_data is 0 whenever ser_en is 0.
- R5: word_ready is 1 only in a cycle with bit_stb and word_valid both 1, and the word is consumed on that edge. A word is taken when a burst starts and on the strobe that follows bit 31 of a word, if more words remain in the burst.
- R6: With cfg_burst_words = 0, no burst starts and no word is consumed.
- R7: dev_busy high at a burst boundary stops the next burst from starting. dev_busy has no effect on a burst that has already started.
- R8: If no word is available inside a burst, ser_en goes low and the burst waits. It resumes when a word arrives, and the burst's total enabled length is still 32·cfg_burst_words slots.
- R9: ser_clk is 0 for exactly the one system cycle after each strobe edge and 1 at all other times. bit_stb must not be 1 on two consecutive cycles.
- R10: A burst starts only on a strobe at which a word is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe that advances one bit slot |
| cfg_burst_words | input | 8 | Burst length in 32-bit words (M) |
| cfg_gap_bits | input | 8 | Idle bit slots between bursts (N) |
| dev_busy | input | 1 | Device busy, holds off the next burst |
| word_valid | input | 1 | Source has a word |
| word_data | input | 32 | Word offered by the source |
| word_ready | output | 1 | Word taken on this edge |
| ser_clk | output | 1 | Serial bit clock, low for one cycle after each update |
| ser_data | output | 1 | Serial data, LSB first |
| ser_en | output | 1 | Data-enable burst output |

## Verification
The assertions check, on every cycle, the rules that hold locally in time:
- word_ready appears only on a strobe with a word offered.
- Outputs hold still between strobes.
- Data is low while enable is low.
- ser_clk follows the strobe.
- No word is taken at a boundary while busy is high.

Burst and gap lengths, LSB-first order, the resume after a mid-burst stall and the zero-size case depend on counts across many strobes. Only the bench's scenarios show these, by comparing against a reference model on every clock.

// File: rtl/gtx_pkg.sv
// Package: shared types for the burst-gated serial transmitter.
// Assumes: nothing; it holds only the phase encoding used by the controller.
package gtx_pkg;
    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,   // at a burst boundary, waiting to start
        PH_SEND = 2'd1,   // inside a burst (sending or stalled)
        PH_GAP  = 2'd2    // emitting idle slots between bursts
    } phase_e;
endpackage

// File: rtl/gtx_word_shifter.sv
// Module: gtx_word_shifter
// Holds the word on the line. It shifts toward the LSB on each shift request
// and tracks the bit index so the controller knows when the last bit is out.
// Assumes: load and shift are never requested in the same cycle.
module gtx_word_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              lsb,
    output logic              last_bit
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    // Load a new word or shift the current one by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign lsb      = sh_q[0];
    assign last_bit = (idx_q == LAST_IDX);
endmodule

// File: rtl/gtx_burst_ctrl.sv
// Module: gtx_burst_ctrl
// Burst and gap sequencer. On each bit strobe it decides whether to start a
// burst, shift a bit, fetch the next word, stall, or emit an idle gap slot.
// Assumes: cfg inputs are read live; M is taken at burst start and N at burst end.
module gtx_burst_ctrl
    import gtx_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic [CFG_W-1:0] cfg_m,
    input  logic [CFG_W-1:0] cfg_n,
    input  logic             dev_busy,
    input  logic             word_valid,
    input  logic             word_done,
    output logic             load,
    output logic             shift,
    output logic             en,
    output logic             in_burst
);
    localparam logic [CFG_W-1:0] ONE = CFG_W'(1);

    phase_e           ph_q, ph_d;
    logic [CFG_W-1:0] words_left_q, words_left_d;
    logic [CFG_W-1:0] gap_q, gap_d;
    logic             en_q, en_d;
    logic             load_c, shift_c, start_ok;

    assign start_ok = (cfg_m != '0) && !dev_busy && word_valid;

    // Next-state decision for the slot that the coming strobe opens.
    always_comb begin
        ph_d         = ph_q;
        words_left_d = words_left_q;
        gap_d        = gap_q;
        en_d         = en_q;
        load_c       = 1'b0;
        shift_c      = 1'b0;
        case (ph_q)
            PH_SEND: begin
                if (en_q && !word_done) begin
                    shift_c = 1'b1;
                end else if (en_q && words_left_q == '0) begin
                    if (cfg_n != '0) begin
                        ph_d  = PH_GAP;
                        gap_d = cfg_n - ONE;
                        en_d  = 1'b0;
                    end else if (start_ok) begin
                        load_c       = 1'b1;
                        words_left_d = cfg_m - ONE;
                        en_d         = 1'b1;
                    end else begin
                        ph_d = PH_WAIT;
                        en_d = 1'b0;
                    end
                end else if (word_valid) begin
                    load_c       = 1'b1;
                    words_left_d = words_left_q - ONE;
                    en_d         = 1'b1;
                end else begin
                    en_d = 1'b0;
                end
            end
            PH_GAP: begin
                en_d = 1'b0;
                if (gap_q != '0) begin
                    gap_d = gap_q - ONE;
                end else if (start_ok) begin
                    ph_d         = PH_SEND;
                    load_c       = 1'b1;
                    words_left_d = cfg_m - ONE;
                    en_d         = 1'b1;
                end else begin
                    ph_d = PH_WAIT;
                end
            end
            default: begin
                en_d = 1'b0;
                if (start_ok) begin
                    ph_d         = PH_SEND;
                    load_c       = 1'b1;
                    words_left_d = cfg_m - ONE;
                    en_d         = 1'b1;
                end
            end
        endcase
    end

    // Commit the decision only on a bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q         <= PH_WAIT;
            words_left_q <= '0;
            gap_q        <= '0;
            en_q         <= 1'b0;
        end else if (bit_stb) begin
            ph_q         <= ph_d;
            words_left_q <= words_left_d;
            gap_q        <= gap_d;
            en_q         <= en_d;
        end
    end

    assign load     = bit_stb && load_c;
    assign shift    = bit_stb && shift_c;
    assign en       = en_q;
    assign in_burst = (ph_q == PH_SEND);
endmodule

// File: rtl/burst_gated_tx.sv
// Module: burst_gated_tx (top)
// Serial word transmitter with a programmable burst/gap data-enable and a
// device-busy hold-off. It joins the sequencer and the shifter and makes the
// serial clock.
// Assumes: bit_stb is never high on two consecutive cycles.
module burst_gated_tx #(
    parameter int WORD_W = 32,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic [CFG_W-1:0]  cfg_burst_words,
    input  logic [CFG_W-1:0]  cfg_gap_bits,
    input  logic              dev_busy,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_en
);
    logic load, shift, en, lsb, last_bit, in_burst;
    logic clk_low_q;

    gtx_burst_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
        .cfg_m(cfg_burst_words), .cfg_n(cfg_gap_bits),
        .dev_busy(dev_busy), .word_valid(word_valid), .word_done(last_bit),
        .load(load), .shift(shift), .en(en), .in_burst(in_burst)
    );

    gtx_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .din(word_data), .lsb(lsb), .last_bit(last_bit)
    );

    // Serial clock: low for the one cycle after each bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_low_q <= 1'b0;
        else        clk_low_q <= bit_stb;
    end

    assign ser_clk    = ~clk_low_q;
    assign ser_en     = en;
    assign ser_data   = en & lsb;
    assign word_ready = load;
endmodule

// File: rtl/burst_gated_tx_chk.sv
// Module: burst_gated_tx_chk
// Protocol checker bound to burst_gated_tx. It checks the cycle-local rules of
// the handshake, the output timing and the busy hold-off.
// Assumes: connected through the bind below.
module burst_gated_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic dev_busy,
    input logic word_valid,
    input logic word_ready,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_en,
    input logic in_burst
);
    // R5: a word is taken only on a strobe with a word offered.
    a_r5_ready_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (bit_stb && word_valid));

    // R4: data is quiet while the enable is low.
    a_r4_data_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> !ser_data);

    // R4: outputs move only on a strobe edge.
    a_r4_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> ($stable(ser_en) && $stable(ser_data)));

    // R9: the serial clock goes low right after a strobe.
    a_r9_clk_low_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !ser_clk);

    // R9: the serial clock is high when no strobe preceded.
    a_r9_clk_high_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> ser_clk);

    // R7: no burst starts at a boundary while busy is high.
    a_r7_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && dev_busy && !in_burst) |-> !word_ready);
endmodule

bind burst_gated_tx burst_gated_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .dev_busy(dev_busy),
    .word_valid(word_valid), .word_ready(word_ready), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_en(ser_en), .in_burst(in_burst)
);

// File: tb/sim_burst_gated_tx.sv
// Bench: behavioural reference model compared against the DUT on every clock.
module sim_burst_gated_tx;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, bit_stb, dev_busy, word_valid, word_ready;
    logic        ser_clk, ser_data, ser_en;
    logic [7:0]  cfg_m, cfg_n;
    logic [31:0] word_data;

    burst_gated_tx u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
        .cfg_burst_words(cfg_m), .cfg_gap_bits(cfg_n),
        .dev_busy(dev_busy), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] q[$];
    string req = "R4";

    // next-cycle input requests applied in the drive phase
    bit nb_busy = 0, nb_src = 1;
    logic [7:0] nb_m = 0, nb_n = 0;

    // reference model state
    int ph = 0, bits_left = 0, bitpos = 0, gap = 0, stb_div = 0;
    bit m_en = 0, exp_clk = 1, last_stb = 0;
    logic [31:0] m_word = 0;
    int pops = 0, en_slots = 0, en_falls = 0;
    bit prev_en = 0;

    task automatic chk(input bit ok, input string r, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic try_start(inout bit p);
        if (cfg_m != 0 && !dev_busy && word_valid) begin
            m_word = q[0]; p = 1; bitpos = 0; m_en = 1;
            bits_left = 32 * int'(cfg_m) - 1; ph = 1;
        end else begin
            ph = 0; m_en = 0;
        end
    endtask

    task automatic step(inout bit p);
        if (ph == 1) begin
            if (m_en && bitpos < 31) begin
                bitpos++; bits_left--;
            end else if (m_en && bits_left == 0) begin
                if (cfg_n != 0) begin ph = 2; gap = int'(cfg_n) - 1; m_en = 0; end
                else try_start(p);
            end else if (word_valid) begin
                m_word = q[0]; p = 1; bitpos = 0; m_en = 1; bits_left--;
            end else begin
                m_en = 0;
            end
        end else if (ph == 2) begin
            if (gap > 0) gap--;
            else try_start(p);
        end else begin
            try_start(p);
        end
    endtask

    task automatic one_cycle();
        bit p;
        bit exp_d;
        @(negedge clk);
        exp_d = m_en ? m_word[bitpos] : 1'b0;
        chk(ser_en === m_en, req, "ser_en", ser_en, m_en);
        chk(ser_data === exp_d, req, "ser_data R4", ser_data, exp_d);
        chk(ser_clk === exp_clk, "R9", "ser_clk", ser_clk, exp_clk);
        if (last_stb && ser_en === 1'b1) en_slots++;
        if (last_stb && prev_en && ser_en === 1'b0) en_falls++;
        if (last_stb) prev_en = ser_en;
        stb_div = (stb_div + 1) % 3;
        bit_stb  = (stb_div == 0);
        dev_busy = nb_busy;
        cfg_m    = nb_m;
        cfg_n    = nb_n;
        word_valid = nb_src && q.size() > 0;
        word_data  = (q.size() > 0) ? q[0] : 32'h0;
        #1;
        p = 0;
        if (bit_stb) step(p);
        chk(word_ready === p, "R5", "word_ready", word_ready, p);
        if (p) begin void'(q.pop_front()); pops++; end
        exp_clk  = !bit_stb;
        last_stb = bit_stb;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) one_cycle();
    endtask

    task automatic clear_counts();
        pops = 0; en_slots = 0; en_falls = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        rst_n = 0; bit_stb = 0; dev_busy = 0; word_valid = 0;
        word_data = 0; cfg_m = 0; cfg_n = 0;
        repeat (3) @(negedge clk);
        chk(ser_en === 1'b0, "R1", "reset ser_en", ser_en, 0);
        chk(ser_data === 1'b0, "R1", "reset ser_data", ser_data, 0);
        chk(ser_clk === 1'b1, "R1", "reset ser_clk", ser_clk, 1);
        chk(word_ready === 1'b0, "R1", "reset word_ready", word_ready, 0);
        rst_n = 1;

        // S1: M=1 N=2, three words, checks burst length and gaps
        req = "R2 R3 R4"; nb_m = 1; nb_n = 2; clear_counts();
        q.push_back(32'hA5C3_0F01); q.push_back(32'h8000_0001); q.push_back(32'h1234_5678);
        run(600);
        chk(pops == 3, "R5", "S1 words taken", pops, 3);
        chk(en_slots == 96, "R2", "S1 enabled slots", en_slots, 96);
        chk(en_falls == 3, "R3", "S1 separate bursts", en_falls, 3);

        // S2: M=2 N=0, back-to-back bursts
        req = "R3 R4"; nb_m = 2; nb_n = 0; clear_counts();
        for (int i = 0; i < 4; i++) q.push_back(32'hF0E1_D2C3 ^ (i * 32'h1111_1111));
        run(600);
        chk(en_slots == 128, "R3", "S2 enabled slots", en_slots, 128);
        chk(en_falls == 1, "R3", "S2 no gap between bursts", en_falls, 1);

        // S3: M=4 N=5, 128-bit bursts
        req = "R2 R3"; nb_m = 4; nb_n = 5; clear_counts();
        for (int i = 0; i < 8; i++) q.push_back(32'h0BAD_F00D + i * 32'h0101_0203);
        run(900);
        chk(en_slots == 256, "R2", "S3 enabled slots", en_slots, 256);
        chk(en_falls == 2, "R2", "S3 burst count", en_falls, 2);

        // S4: M=0 disables transmission
        req = "R6"; nb_m = 0; nb_n = 1; clear_counts();
        q.push_back(32'h1); q.push_back(32'h2);
        run(300);
        chk(pops == 0, "R6", "S4 words taken", pops, 0);
        chk(en_slots == 0, "R6", "S4 enabled slots", en_slots, 0);
        q.delete();

        // S5: busy at boundary holds off; busy mid-burst ignored
        req = "R7"; nb_m = 1; nb_n = 1; nb_busy = 1; clear_counts();
        q.push_back(32'hC001_CAFE); q.push_back(32'h7777_0001);
        run(200);
        chk(pops == 0, "R7", "S5 busy blocks start", pops, 0);
        nb_busy = 0;
        for (int i = 0; i < 100 && ser_en !== 1'b1; i++) one_cycle();
        nb_busy = 1;
        run(400);
        chk(en_slots == 32, "R7", "S5 started burst completes", en_slots, 32);
        chk(pops == 1, "R7", "S5 next burst held", pops, 1);
        nb_busy = 0;
        run(300);
        chk(pops == 2, "R7", "S5 resumes after busy", pops, 2);

        // S6: empty source at boundary, then stall mid-burst
        req = "R8 R10"; nb_m = 3; nb_n = 1; clear_counts();
        run(100);
        chk(en_slots == 0, "R10", "S6 no start without word", en_slots, 0);
        q.push_back(32'h5555_AAAA);
        for (int i = 0; i < 100 && ser_en !== 1'b1; i++) one_cycle();
        run(150);
        chk(ser_en === 1'b0, "R8", "S6 enable drops on stall", ser_en, 0);
        q.push_back(32'h0F0F_3C3C); q.push_back(32'hDEAD_BEEF);
        run(700);
        chk(en_slots == 96, "R8", "S6 burst length after stall", en_slots, 96);
        chk(pops == 3, "R8", "S6 words taken", pops, 3);
        chk(en_falls == 2, "R8", "S6 one stall one end", en_falls, 2);

        finish_up();
    end
endmodule